// File: doc/BRIEF.md
# Edge-Triggered Counter Snapshot Unit with Glitch Filter

This block watches an asynchronous capture input and, when a chosen transition appears on it, copies the current value of an external free-running counter into a holding register. The same transition raises a sticky capture flag. When the interrupt enable is set, the flag also drives an interrupt request. The counter, waveform generation and any register access belong to the surrounding timer. This block only receives the count as an input.

The input first passes through a two-flop synchronizer. An optional glitch filter can then sit in front of the edge detector. When the filter is on, the level seen by the edge detector changes only after four consecutive synchronized samples agree on a new value, so a capture arrives four clock cycles later than without the filter. A capture-inhibit input switches captures off completely. The timer asserts it while the holding register serves as the counter's upper limit.

The flag state machine has two states, FLAG_IDLE and FLAG_PENDING. It takes these transitions:
- FLAG_IDLE to FLAG_PENDING on a capture event.
- FLAG_PENDING to FLAG_IDLE on a clear strobe that has no capture in the same cycle.
- FLAG_PENDING stays in FLAG_PENDING on a capture, with or without a clear.
- FLAG_IDLE stays in FLAG_IDLE otherwise.

Top module: `icap_unit`

## Requirements
- R1: After reset, the captured value is 0, the flag is 0 and the interrupt request is 0. All controls are reset-level 0, which means filter off and falling-edge trigger.
- R2: With the filter off, a pin change driven before clock edge e1 is captured at edge e3, two flops of synchronization plus one register stage. The stored value is the count presented at e3, which is the count at e1 plus 2 when the count advances once per cycle.
- R3: With `edge_rise`=0, only a 1-to-0 transition of the pin triggers a capture. With `edge_rise`=1, only a 0-to-1 transition does. The opposite transition leaves the value and the flag unchanged.
- R4: On a capture event, `cap_value` takes the `count_in` value present in that cycle, and it holds that value until the next capture.
- R5: With `filt_en`=1, a synchronized level that lasts 3 cycles is ignored, and one that lasts 4 cycles is accepted. With `filt_en`=0, even a 1-cycle pulse is accepted.
- R6: With `filt_en`=1, the capture happens 4 cycles later than on the unfiltered path, at count-at-e1 plus 6.
- R7: The flag stays at 1 until a `flag_clr` strobe. A strobe in a cycle without a capture returns the flag to 0.
- R8: When `flag_clr` and a capture event fall in the same cycle, the flag stays at 1 and the value loads.
- R9: `cap_irq` is 1 exactly when the flag is 1 and `irq_en` is 1.
- R10: While `cap_inhibit`=1, pin transitions of either direction cause no capture. The value and the flag stay unchanged.
- R11: Changing `edge_rise` or `filt_en` while the pin is steady produces no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin | input | 1 | Asynchronous capture input |
| count_in | input | CNT_W (16) | Counter value to snapshot |
| filt_en | input | 1 | 1 = four-sample glitch filter active |
| edge_rise | input | 1 | 0 = falling edge triggers, 1 = rising edge triggers |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | One-cycle strobe that clears the flag |
| cap_inhibit | input | 1 | 1 = captures disabled (holding register used as limit) |
| cap_value | output | CNT_W (16) | Captured counter value |
| cap_flag | output | 1 | Sticky capture flag |
| cap_irq | output | 1 | Interrupt request |

## Verification
A capture event and a flag-clear strobe can fall in the same clock cycle. The bench provokes this by raising `flag_clr` exactly on the cycle it computes as the capture cycle: two cycles after the pin change, plus four more with the filter on. It then expects the flag to remain set and the value to equal that cycle's count. A clear strobe issued alone, with no capture in its cycle, is checked to drop the flag. Both outcomes are compared against counts derived arithmetically from the cycle at which the pin was driven.

// File: rtl/icap_pkg.sv
package icap_pkg;

    typedef enum logic {
        FLAG_IDLE    = 1'b0,
        FLAG_PENDING = 1'b1
    } flag_state_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_pair_t;

endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/icap_filter.sv
module icap_filter #(
    parameter int TAPS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int HIST_W = TAPS - 1;

    logic [HIST_W-1:0] hist_q;
    logic [TAPS-1:0]   window;
    logic              all_high;
    logic              all_low;
    logic              level_q;

    assign window   = {hist_q, din};
    assign all_high = &window;
    assign all_low  = ~|window;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q  <= '0;
            level_q <= 1'b0;
        end else begin
            hist_q <= window[HIST_W-1:0];
            if (all_high)     level_q <= 1'b1;
            else if (all_low) level_q <= 1'b0;
        end
    end

    assign dout = level_q;
endmodule

// File: rtl/icap_edge.sv
module icap_edge
    import icap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic edge_rise,
    input  logic inhibit,
    output logic trig
);
    logic       prev_q;
    edge_pair_t seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    always_comb begin
        seen.rise = level & ~prev_q;
        seen.fall = ~level & prev_q;
        trig      = ~inhibit & (edge_rise ? seen.rise : seen.fall);
    end
endmodule

// File: rtl/icap_flag_fsm.sv
module icap_flag_fsm
    import icap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic clr,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    flag_state_t state_q;
    flag_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE:    if (trig)        state_d = FLAG_PENDING;
            FLAG_PENDING: if (clr && !trig) state_d = FLAG_IDLE;
            default:                        state_d = FLAG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        flag = 1'b0;
        unique case (state_q)
            FLAG_IDLE:    flag = 1'b0;
            FLAG_PENDING: flag = 1'b1;
            default:      flag = 1'b0;
        endcase
        irq = flag & irq_en;
    end
endmodule

// File: rtl/icap_unit.sv
module icap_unit #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_TAPS   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_pin,
    input  logic [CNT_W-1:0] count_in,
    input  logic             filt_en,
    input  logic             edge_rise,
    input  logic             irq_en,
    input  logic             flag_clr,
    input  logic             cap_inhibit,
    output logic [CNT_W-1:0] cap_value,
    output logic             cap_flag,
    output logic             cap_irq
);
    logic             pin_sync;
    logic             pin_filt;
    logic             level_sel;
    logic             trig_evt;
    logic [CNT_W-1:0] value_q;

    icap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (cap_pin),
        .dout (pin_sync)
    );

    icap_filter #(.TAPS(FILT_TAPS)) u_filter (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_sync),
        .dout (pin_filt)
    );

    assign level_sel = filt_en ? pin_filt : pin_sync;

    icap_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (level_sel),
        .edge_rise(edge_rise),
        .inhibit  (cap_inhibit),
        .trig     (trig_evt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        value_q <= '0;
        else if (trig_evt) value_q <= count_in;
    end

    icap_flag_fsm u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (trig_evt),
        .clr   (flag_clr),
        .irq_en(irq_en),
        .flag  (cap_flag),
        .irq   (cap_irq)
    );

    assign cap_value = value_q;
endmodule

// File: rtl/icap_unit_chk.sv
module icap_unit_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trig,
    input logic [CNT_W-1:0] count_in,
    input logic             irq_en,
    input logic             flag_clr,
    input logic             cap_inhibit,
    input logic [CNT_W-1:0] cap_value,
    input logic             cap_flag,
    input logic             cap_irq
);
    assert_load_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (cap_value == $past(count_in)));

    assert_flag_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> cap_flag);

    assert_flag_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_flag) |-> $past(trig));

    assert_clear_alone_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !trig) |=> !cap_flag);

    assert_capture_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && trig) |=> (cap_flag && (cap_value == $past(count_in))));

    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_irq |-> (cap_flag && irq_en));

    assert_inhibit_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cap_inhibit |=> ($stable(cap_value) && ($past(cap_flag) || !cap_flag)));
endmodule

bind icap_unit icap_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig       (trig_evt),
    .count_in   (count_in),
    .irq_en     (irq_en),
    .flag_clr   (flag_clr),
    .cap_inhibit(cap_inhibit),
    .cap_value  (cap_value),
    .cap_flag   (cap_flag),
    .cap_irq    (cap_irq)
);

// File: tb/tb_icap_unit.sv
module tb_icap_unit;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cap_pin = 1'b0;
    logic [CW-1:0] cnt = '0;
    logic          filt_en = 1'b0;
    logic          edge_rise = 1'b0;
    logic          irq_en = 1'b0;
    logic          flag_clr = 1'b0;
    logic          cap_inhibit = 1'b0;
    logic [CW-1:0] cap_value;
    logic          cap_flag;
    logic          cap_irq;

    int vectors = 0;
    int misses = 0;
    bit finished = 0;

    icap_unit dut (
        .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .count_in(cnt),
        .filt_en(filt_en), .edge_rise(edge_rise), .irq_en(irq_en),
        .flag_clr(flag_clr), .cap_inhibit(cap_inhibit),
        .cap_value(cap_value), .cap_flag(cap_flag), .cap_irq(cap_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) cnt <= cnt + 1'b1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic clear_flag();
        wait_cyc(1);
        flag_clr = 1'b1;
        wait_cyc(1);
        flag_clr = 1'b0;
        check(cap_flag == 1'b0, "R7 clear", cap_flag, 0);
    endtask

    // toggle the pin and verify the outcome after everything has settled
    task automatic toggle_check(input bit expect_cap, input int lat, input string req);
        logic [CW-1:0] c0, old;
        wait_cyc(1);
        c0 = cnt;
        old = cap_value;
        cap_pin = ~cap_pin;
        wait_cyc(12);
        if (expect_cap) begin
            check(cap_value == CW'(c0 + lat), req, cap_value, CW'(c0 + lat));
            check(cap_flag == 1'b1, req, cap_flag, 1);
            check(cap_irq == irq_en, "R9", cap_irq, irq_en);
        end else begin
            check(cap_value == old, req, cap_value, old);
            check(cap_flag == 1'b0, req, cap_flag, 0);
            check(cap_irq == 1'b0, "R9", cap_irq, 0);
        end
    endtask

    // pulse the pin away from its idle level for w cycles
    task automatic pulse_check(input int w, input bit expect_cap, input int lat, input string req);
        logic [CW-1:0] c0, old;
        wait_cyc(1);
        c0 = cnt;
        old = cap_value;
        cap_pin = ~cap_pin;
        wait_cyc(w);
        cap_pin = ~cap_pin;
        wait_cyc(12);
        if (expect_cap) begin
            check(cap_value == CW'(c0 + lat), req, cap_value, CW'(c0 + lat));
            check(cap_flag == 1'b1, req, cap_flag, 1);
        end else begin
            check(cap_value == old, req, cap_value, old);
            check(cap_flag == 1'b0, req, cap_flag, 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            misses++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        // R1: reset state
        check(cap_value == '0, "R1 value", cap_value, 0);
        check(cap_flag == 1'b0, "R1 flag", cap_flag, 0);
        check(cap_irq == 1'b0, "R1 irq", cap_irq, 0);
        rst_n = 1'b1;
        wait_cyc(6);
        check(cap_flag == 1'b0, "R1 idle", cap_flag, 0);

        // R2 R3 R4 R6 R9: sweep edge select, filter and irq enable
        for (int es = 0; es < 2; es++) begin
            for (int fe = 0; fe < 2; fe++) begin
                for (int ie = 0; ie < 2; ie++) begin
                    wait_cyc(1);
                    edge_rise = es[0];
                    filt_en = fe[0];
                    irq_en = ie[0];
                    for (int k = 0; k < 2; k++) begin
                        bit nxt;
                        clear_flag();
                        nxt = ~cap_pin;
                        toggle_check((es == 1) ? nxt : ~nxt, fe ? 6 : 2,
                                     fe ? "R6 filtered latency" : "R2 R3 R4 unfiltered");
                    end
                end
            end
        end

        // R11: control changes with a steady pin
        clear_flag();
        for (int k = 0; k < 4; k++) begin
            wait_cyc(2);
            edge_rise = ~edge_rise;
            filt_en = k[1];
        end
        wait_cyc(10);
        check(cap_flag == 1'b0, "R11 no spurious", cap_flag, 0);

        // R5: filter pulse width boundary
        wait_cyc(1);
        edge_rise = 1'b1; filt_en = 1'b1; irq_en = 1'b0;
        if (cap_pin) begin
            edge_rise = 1'b0;
        end
        clear_flag();
        pulse_check(3, 1'b0, 0, "R5 3-cycle rejected");
        pulse_check(4, 1'b1, 6, "R5 4-cycle accepted");
        clear_flag();
        wait_cyc(1);
        filt_en = 1'b0;
        pulse_check(1, 1'b1, 2, "R5 unfiltered 1-cycle");

        // R7: flag sticky with no clear
        wait_cyc(20);
        check(cap_flag == 1'b1, "R7 sticky", cap_flag, 1);

        // R8: clear in the capture cycle, for both latencies
        for (int fe = 0; fe < 2; fe++) begin
            logic [CW-1:0] c0;
            int lat;
            lat = fe ? 6 : 2;
            wait_cyc(1);
            filt_en = fe[0];
            edge_rise = ~cap_pin;
            wait_cyc(1);
            c0 = cnt;
            cap_pin = ~cap_pin;
            wait_cyc(lat);
            flag_clr = 1'b1;
            wait_cyc(1);
            flag_clr = 1'b0;
            check(cap_flag == 1'b1, "R8 capture wins", cap_flag, 1);
            check(cap_value == CW'(c0 + lat), "R8 value", cap_value, CW'(c0 + lat));
            clear_flag();
        end

        // R10: inhibit blocks both directions
        wait_cyc(1);
        cap_inhibit = 1'b1;
        filt_en = 1'b0;
        for (int k = 0; k < 2; k++) begin
            edge_rise = k[0];
            toggle_check(1'b0, 0, "R10 inhibited");
            toggle_check(1'b0, 0, "R10 inhibited");
        end
        wait_cyc(1);
        cap_inhibit = 1'b0;
        wait_cyc(8);
        check(cap_flag == 1'b0, "R10 release", cap_flag, 0);
        edge_rise = ~cap_pin;
        toggle_check(1'b1, 2, "R10 after release");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule